// File: doc/BRIEF.md
# Speculative Load Memory-Ordering Gate

This block decides, for each speculative load, whether the load may go ahead and read memory. Stores wait in the reorder buffer and reach memory only when they commit from its head. Until then, a load must not read a location that an older, still uncommitted store will write. The block keeps its own table of the in-flight stores. The reorder buffer updates the table through three write ports: allocate a slot for a new store, record the store's resolved word address, and release the slot when the store commits. A flush empties the whole table.

A load request carries a word address and its reorder-buffer age tag. The block compares the load against every valid store entry that is older. Age is the circular distance of a tag from the current reorder-buffer head. The load is blocked in two cases: any older store has no address yet, or any older store has exactly the load's address. A blocked load is retried later by the requester. Stores with the same tag as the load, or younger stores, play no part. The verdict is registered and appears one cycle after the request.

The request stream is valid-only and has no back-pressure. A request is taken in every cycle in which `ld_valid` is high. The verdict stream is also valid-only, and its consumer must take each verdict in the cycle it is shown. Table updates are plain control pins.

Top module: `load_order_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0, and the store table is empty.
- R2: A load that has no valid older store in the table gets `res_valid`=1, `res_grant`=1 and `res_wait_addr`=0.
- R3: A load is blocked (`res_grant`=0) if a valid older store has a known address equal to the load address. In that case `res_wait_addr`=0 unless R4 also applies.
- R4: A load is blocked with `res_wait_addr`=1 if any valid older store has no address yet. An entry has no address from its allocation until its address update.
- R5: Older means (store tag − head) mod 2^TAG_W < (load tag − head) mod 2^TAG_W. A store that is younger than the load, or has an equal tag, has no effect on the verdict, and this holds across tag wrap-around.
- R6: An older store whose known address differs from the load address does not block the load.
- R7: Releasing a slot on commit removes its store, so a later load to that address is granted.
- R8: A flush invalidates every entry in one cycle. A load presented in the flush cycle produces no verdict (`res_valid`=0 in the next cycle).
- R9: `res_valid` is 1 exactly in the cycle after a cycle that has `ld_valid`=1 and `flush`=0. Table updates take effect on verdicts for loads presented in the next cycle or later.
- R10: An allocation in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rob_head | input | TAG_W | Tag of the oldest reorder-buffer entry |
| alloc_valid | input | 1 | Allocate a store slot |
| alloc_slot | input | SLOT_W | Slot to allocate |
| alloc_tag | input | TAG_W | Age tag of the new store |
| addr_valid | input | 1 | Record a store's resolved address |
| addr_slot | input | SLOT_W | Slot whose address is resolved |
| addr_value | input | ADDR_W | Resolved word address |
| free_valid | input | 1 | Release a slot at commit |
| free_slot | input | SLOT_W | Slot to release |
| flush | input | 1 | Invalidate all entries and drop the current request |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | ADDR_W | Load word address |
| ld_tag | input | TAG_W | Load age tag |
| res_valid | output | 1 | Verdict present |
| res_grant | output | 1 | 1: load may access memory |
| res_wait_addr | output | 1 | Block is due to an older store with no address yet |

## Verification
Every verdict is due exactly one clock edge after its request. Table updates made in one cycle govern loads presented from the next cycle on. Inputs are driven on the falling edge. The bench reads the verdict at the following falling edge, which lies after the one rising edge that registers it. Steps that carry no load check that `res_valid` is 0 at that same point. A load driven together with a flush is checked one falling edge later for an absent verdict.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    VERD_GO    = 2'd0,
    VERD_ALIAS = 2'd1,
    VERD_NOADR = 2'd2
  } verdict_e;
endpackage

// File: rtl/lsq_age_cmp.sv
module lsq_age_cmp #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] head,
  input  logic [TAG_W-1:0] st_tag,
  input  logic [TAG_W-1:0] ld_tag,
  output logic             st_older
);
  logic [TAG_W-1:0] st_dist, ld_dist;
  always_comb begin
    st_dist  = st_tag - head;
    ld_dist  = ld_tag - head;
    st_older = (st_dist < ld_dist);
  end
endmodule

// File: rtl/lsq_store_table.sv
module lsq_store_table #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              addr_valid,
  input  logic [SLOT_W-1:0] addr_slot,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              free_valid,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [SLOTS-1:0]  ent_valid,
  output logic [SLOTS-1:0]  ent_known,
  output logic [ADDR_W-1:0] ent_addr [SLOTS],
  output logic [TAG_W-1:0]  ent_tag  [SLOTS]
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_alloc, hit_addr, hit_free;
    assign hit_alloc = alloc_valid && (alloc_slot == SLOT_W'(s));
    assign hit_addr  = addr_valid  && (addr_slot  == SLOT_W'(s));
    assign hit_free  = free_valid  && (free_slot  == SLOT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[s] <= 1'b0;
        ent_known[s] <= 1'b0;
        ent_addr[s]  <= '0;
        ent_tag[s]   <= '0;
      end else if (flush) begin
        ent_valid[s] <= 1'b0;
        ent_known[s] <= 1'b0;
      end else if (hit_alloc) begin
        ent_valid[s] <= 1'b1;
        ent_known[s] <= 1'b0;
        ent_tag[s]   <= alloc_tag;
      end else if (hit_free) begin
        ent_valid[s] <= 1'b0;
        ent_known[s] <= 1'b0;
      end else if (hit_addr && ent_valid[s]) begin
        ent_known[s] <= 1'b1;
        ent_addr[s]  <= addr_value;
      end
    end
  end
endmodule

// File: rtl/lsq_hazard_scan.sv
module lsq_hazard_scan
  import lsq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic [TAG_W-1:0]  head,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [SLOTS-1:0]  ent_valid,
  input  logic [SLOTS-1:0]  ent_known,
  input  logic [ADDR_W-1:0] ent_addr [SLOTS],
  input  logic [TAG_W-1:0]  ent_tag  [SLOTS],
  output verdict_e          verdict
);
  logic [SLOTS-1:0] older, unk_hit, alias_hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    lsq_age_cmp #(.TAG_W(TAG_W)) u_age (
      .head    (head),
      .st_tag  (ent_tag[s]),
      .ld_tag  (ld_tag),
      .st_older(older[s])
    );
    assign unk_hit[s]   = ent_valid[s] && older[s] && !ent_known[s];
    assign alias_hit[s] = ent_valid[s] && older[s] && ent_known[s]
                          && (ent_addr[s] == ld_addr);
  end

  always_comb begin
    if (|unk_hit)        verdict = VERD_NOADR;
    else if (|alias_hit) verdict = VERD_ALIAS;
    else                 verdict = VERD_GO;
  end
endmodule

// File: rtl/load_order_check.sv
module load_order_check
  import lsq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  rob_head,
  input  logic              alloc_valid,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              addr_valid,
  input  logic [SLOT_W-1:0] addr_slot,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              free_valid,
  input  logic [SLOT_W-1:0] free_slot,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              res_valid,
  output logic              res_grant,
  output logic              res_wait_addr
);
  logic [SLOTS-1:0]  ent_valid, ent_known;
  logic [ADDR_W-1:0] ent_addr [SLOTS];
  logic [TAG_W-1:0]  ent_tag  [SLOTS];
  verdict_e          verdict;

  lsq_store_table #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_valid(alloc_valid),
    .alloc_slot (alloc_slot),
    .alloc_tag  (alloc_tag),
    .addr_valid (addr_valid),
    .addr_slot  (addr_slot),
    .addr_value (addr_value),
    .free_valid (free_valid),
    .free_slot  (free_slot),
    .ent_valid  (ent_valid),
    .ent_known  (ent_known),
    .ent_addr   (ent_addr),
    .ent_tag    (ent_tag)
  );

  lsq_hazard_scan #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_scan (
    .head     (rob_head),
    .ld_addr  (ld_addr),
    .ld_tag   (ld_tag),
    .ent_valid(ent_valid),
    .ent_known(ent_known),
    .ent_addr (ent_addr),
    .ent_tag  (ent_tag),
    .verdict  (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_grant     <= 1'b0;
      res_wait_addr <= 1'b0;
    end else begin
      res_valid     <= ld_valid && !flush;
      res_grant     <= (verdict == VERD_GO);
      res_wait_addr <= (verdict == VERD_NOADR);
    end
  end
endmodule

// File: rtl/lsq_order_chk.sv
module lsq_order_chk (
  input logic clk,
  input logic rst_n,
  input logic flush,
  input logic alloc_valid,
  input logic ld_valid,
  input logic res_valid,
  input logic res_grant,
  input logic res_wait_addr
);
  // R9: a request outside a flush yields a verdict on the next cycle
  assert_verdict_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !flush) |=> res_valid);

  // R8: a load that meets a flush is dropped
  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid);

  // R8 / R2: the cycle after a flush the table is empty, so a load is granted
  assert_empty_after_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush ##1 ld_valid) |=> (res_valid && res_grant && !res_wait_addr));

  // R10: an allocation together with a flush leaves the table empty
  assert_flush_beats_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && alloc_valid ##1 ld_valid && !alloc_valid && !flush) |=> res_grant);

  // R4: a wait-for-address verdict is never a grant
  assert_wait_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wait_addr) |-> !res_grant);

  // R9: no verdict without a request in the cycle before
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);
endmodule

bind load_order_check lsq_order_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .alloc_valid  (alloc_valid),
  .ld_valid     (ld_valid),
  .res_valid    (res_valid),
  .res_grant    (res_grant),
  .res_wait_addr(res_wait_addr)
);

// File: tb/load_order_check_tb.sv
module load_order_check_tb;
  localparam int SLOTS = 8, ADDR_W = 32, TAG_W = 4, SLOT_W = 3;
  localparam logic [2:0] K_LD = 3'd0, K_AL = 3'd1, K_AD = 3'd2,
                         K_FR = 3'd3, K_FL = 3'd4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  slot;
    logic [3:0]  tag;
    logic [31:0] addr;
    logic [3:0]  head;
    logic        grant;
    logic        wait_a;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  // kind, slot, tag, addr, head, exp grant, exp wait, requirement number
  localparam vec_t VECS [NV] = '{
    '{K_LD, 3'd0, 4'd5,  32'h100, 4'd0,  1'b1, 1'b0, 8'd2}, // R2 empty table
    '{K_AL, 3'd0, 4'd2,  32'h0,   4'd0,  1'b0, 1'b0, 8'd9},
    '{K_LD, 3'd0, 4'd5,  32'h100, 4'd0,  1'b0, 1'b1, 8'd4}, // R4 unknown addr
    '{K_AD, 3'd0, 4'd0,  32'h100, 4'd0,  1'b0, 1'b0, 8'd9},
    '{K_LD, 3'd0, 4'd5,  32'h100, 4'd0,  1'b0, 1'b0, 8'd3}, // R3 alias
    '{K_LD, 3'd0, 4'd5,  32'h104, 4'd0,  1'b1, 1'b0, 8'd6}, // R6 other addr
    '{K_LD, 3'd0, 4'd1,  32'h100, 4'd0,  1'b1, 1'b0, 8'd5}, // R5 younger store
    '{K_LD, 3'd0, 4'd2,  32'h100, 4'd0,  1'b1, 1'b0, 8'd5}, // R5 equal tag
    '{K_AL, 3'd3, 4'd9,  32'h0,   4'd0,  1'b0, 1'b0, 8'd9},
    '{K_AD, 3'd3, 4'd0,  32'h200, 4'd0,  1'b0, 1'b0, 8'd9},
    '{K_LD, 3'd0, 4'd12, 32'h200, 4'd0,  1'b0, 1'b0, 8'd3}, // R3 second slot
    '{K_LD, 3'd0, 4'd12, 32'h200, 4'd10, 1'b1, 1'b0, 8'd5}, // R5 wrap, younger
    '{K_LD, 3'd0, 4'd1,  32'h200, 4'd8,  1'b0, 1'b0, 8'd5}, // R5 wrap, older
    '{K_FR, 3'd3, 4'd0,  32'h0,   4'd0,  1'b0, 1'b0, 8'd9},
    '{K_LD, 3'd0, 4'd12, 32'h200, 4'd0,  1'b1, 1'b0, 8'd7}, // R7 released
    '{K_LD, 3'd0, 4'd12, 32'h100, 4'd0,  1'b0, 1'b0, 8'd3},
    '{K_FL, 3'd0, 4'd0,  32'h0,   4'd0,  1'b0, 1'b0, 8'd9},
    '{K_LD, 3'd0, 4'd12, 32'h100, 4'd0,  1'b1, 1'b0, 8'd8}  // R8 emptied
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TAG_W-1:0]  rob_head = '0, alloc_tag = '0, ld_tag = '0;
  logic              alloc_valid = 0, addr_valid = 0, free_valid = 0, flush = 0, ld_valid = 0;
  logic [SLOT_W-1:0] alloc_slot = '0, addr_slot = '0, free_slot = '0;
  logic [ADDR_W-1:0] addr_value = '0, ld_addr = '0;
  logic              res_valid, res_grant, res_wait_addr;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  load_order_check #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rob_head(rob_head),
    .alloc_valid(alloc_valid), .alloc_slot(alloc_slot), .alloc_tag(alloc_tag),
    .addr_valid(addr_valid), .addr_slot(addr_slot), .addr_value(addr_value),
    .free_valid(free_valid), .free_slot(free_slot), .flush(flush),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .res_valid(res_valid), .res_grant(res_grant), .res_wait_addr(res_wait_addr)
  );

  task automatic check(input string rq, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,grant,wait} actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; addr_valid = 0; free_valid = 0; flush = 0; ld_valid = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 in reset", {res_valid, 2'b00}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {res_valid, 2'b00}, 3'b000);
    ld_valid = 1; ld_addr = 32'h40; ld_tag = 4'd7;
    @(negedge clk);
    idle_inputs();
    check("R1 empty table", {res_valid, res_grant, res_wait_addr}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      rob_head = v.head;
      case (v.kind)
        K_LD: begin ld_valid = 1; ld_addr = v.addr; ld_tag = v.tag; end
        K_AL: begin alloc_valid = 1; alloc_slot = v.slot; alloc_tag = v.tag; end
        K_AD: begin addr_valid = 1; addr_slot = v.slot; addr_value = v.addr; end
        K_FR: begin free_valid = 1; free_slot = v.slot; end
        default: flush = 1;
      endcase
      @(negedge clk);
      idle_inputs();
      if (v.kind == K_LD)
        check($sformatf("R%0d vector %0d", v.req, i),
              {res_valid, res_grant, res_wait_addr}, {1'b1, v.grant, v.wait_a});
      else
        check($sformatf("R9 no verdict, vector %0d", i), {res_valid, 2'b00}, 3'b000);
    end
    rob_head = '0;

    // R8: a load in the flush cycle gives no verdict
    alloc_valid = 1; alloc_slot = 3'd5; alloc_tag = 4'd1;
    @(negedge clk);
    idle_inputs();
    flush = 1; ld_valid = 1; ld_addr = 32'h300; ld_tag = 4'd6;
    @(negedge clk);
    idle_inputs();
    check("R8 dropped load", {res_valid, 2'b00}, 3'b000);

    // R10: an allocation in the flush cycle is discarded
    flush = 1; alloc_valid = 1; alloc_slot = 3'd2; alloc_tag = 4'd1;
    @(negedge clk);
    idle_inputs();
    ld_valid = 1; ld_addr = 32'h500; ld_tag = 4'd6;
    @(negedge clk);
    idle_inputs();
    check("R10 alloc during flush", {res_valid, res_grant, res_wait_addr}, 3'b110);

    // R4 with R3: unknown and alias together report the wait reason
    alloc_valid = 1; alloc_slot = 3'd1; alloc_tag = 4'd1;
    @(negedge clk);
    addr_valid = 1; addr_slot = 3'd1; addr_value = 32'h600;
    alloc_slot = 3'd4; alloc_tag = 4'd2;
    @(negedge clk);
    idle_inputs();
    ld_valid = 1; ld_addr = 32'h600; ld_tag = 4'd6;
    @(negedge clk);
    idle_inputs();
    check("R4 wait beats alias", {res_valid, res_grant, res_wait_addr}, 3'b101);

    // R9: an update in the load's own cycle does not affect that load
    free_valid = 1; free_slot = 3'd4; ld_valid = 1; ld_addr = 32'h700; ld_tag = 4'd6;
    @(negedge clk);
    idle_inputs();
    check("R9 same-cycle release", {res_valid, res_grant, res_wait_addr}, 3'b101);
    ld_valid = 1;
    @(negedge clk);
    idle_inputs();
    check("R7 release then grant", {res_valid, res_grant, res_wait_addr}, 3'b110);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule